// File: doc/BRIEF.md
# Lockable Low-Memory Region Decoder

This block holds one 32-bit configuration register that sets the upper limit of usable DRAM below 4 GB, in 1 MB steps. Two reserved areas sit just beneath that limit: a graphics carve-out directly under it, and a secure management segment under the graphics area. Their bases are not programmed. The block computes each one by subtracting the selected sizes from the limit. Every incoming address is then sorted into one of four classes: usable DRAM, graphics carve-out, secure segment or non-DRAM.

The register is written through a simple port that carries a per-byte write strobe, and reads return its current contents. Once its self-lock bit is set, the register accepts no further writes until reset. A separate platform-wide lock input blocks writes for as long as it is held high. The enable and size select for each carve-out arrive on input pins.

The address class appears two ways: combinationally from the address and the stored state, and again one clock later from a register, for timing. If a subtraction would fall below zero, the base is clamped to zero and a sticky error flag is raised.

Top module: `lowmem_region_decoder`

## Requirements
- R1: While reset is asserted and just after it, the read value is 0x0010_0000 (limit of 1 MB, unlocked), the error flag is 0 and the registered class is 0.
- R2: Reads return the limit in bits 31:20 and the lock in bit 0. Bits 19:1 always read as zero, and writing ones to them has no effect.
- R3: Byte strobe 3 updates limit bits 31:24 and strobe 2 updates limit bits 23:20. Strobe 0 updates the lock bit. Strobe 1 changes nothing.
- R4: After a 1 is written into the lock bit, every later write is ignored, including writes to the lock bit itself, until reset.
- R5: While the platform lock input is high, writes are ignored, whatever the value of the lock bit.
- R6: The graphics size select picks 0=1 MB or 1=2 MB. The secure size select picks 00=1 MB, 01=2 MB, or 10/11=8 MB. A disabled carve-out has zero size. The graphics base (MB units) is the limit minus the graphics size, and the secure base is the graphics base minus the secure size.
- R7: A base whose subtraction would go below zero reads 0. From the next clock edge on, the error flag is 1 and stays 1 until reset.
- R8: The class codes are 0=non-DRAM, 1=usable DRAM, 2=graphics, 3=secure. An address whose bits 31:20 are at or above the limit is class 0. Otherwise the class is 3 if the secure area is enabled and the address lies in [secure base, graphics base). Failing that, it is 2 if the graphics area is enabled and the address is at or above the graphics base. Failing both, it is 1.
- R9: The registered class output equals the combinational class of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_wr_en | input | 1 | Register write request |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_strb | input | 4 | Per-byte write strobe |
| cfg_rd_data | output | 32 | Current register value |
| plat_lock_i | input | 1 | Platform-wide write lock |
| gfx_en_i | input | 1 | Graphics carve-out enable |
| gfx_sel_i | input | 1 | Graphics carve-out size select |
| seg_en_i | input | 1 | Secure segment enable |
| seg_sel_i | input | 2 | Secure segment size select |
| addr_i | input | 32 | Address to classify |
| region_o | output | 2 | Combinational class |
| region_q | output | 2 | Registered class, one cycle later |
| gfx_base_o | output | 12 | Graphics base in MB |
| seg_base_o | output | 12 | Secure base in MB |
| cfg_err_o | output | 1 | Sticky underflow flag |

## Verification
The properties assume that reset is applied before any write, and that the size selects and enables may change on any cycle. They check only relations that hold for every register value, such as base ordering, classes above the limit and frozen contents under either lock, so they need no restriction on the address or the write data. The stimulus keeps the self-lock bit clear until the final directed phase, so that the random phase keeps reprogramming the limit. It toggles the platform lock at random, and it biases addresses to land one below, at and one above each derived boundary.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    localparam int REGION_W = 2;

    typedef enum logic [REGION_W-1:0] {
        RG_NONDRAM = 2'd0,
        RG_DRAM    = 2'd1,
        RG_GFX     = 2'd2,
        RG_SEG     = 2'd3
    } region_e;

    // Graphics carve-out size in MB for its select input
    function automatic int unsigned gfx_mb(input logic sel);
        return sel ? 32'd2 : 32'd1;
    endfunction

    // Secure segment size in MB for its select input
    function automatic int unsigned seg_mb(input logic [1:0] sel);
        if (sel[1]) return 32'd8;
        return sel[0] ? 32'd2 : 32'd1;
    endfunction

endpackage

// File: rtl/lmd_cfg_reg.sv
module lmd_cfg_reg #(
    parameter int DATA_W   = 32,
    parameter int GRAN_LSB = 20,
    parameter int TOP_RST  = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [DATA_W/8-1:0]          wr_strb,
    input  logic                         plat_lock,
    output logic [DATA_W-GRAN_LSB-1:0]   top_o,
    output logic                         lock_o,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int TOP_W = DATA_W - GRAN_LSB;

    typedef struct packed {
        logic [TOP_W-1:0] top;
        logic             lock;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_ok;
    logic unused_bits;

    assign unused_bits = ^{wr_data, wr_strb};

    always_comb begin
        cfg_d = cfg_q;
        wr_ok = wr_en && !cfg_q.lock && !plat_lock;
        if (wr_ok) begin
            for (int b = 0; b < TOP_W; b++) begin
                if (wr_strb[(b + GRAN_LSB) / 8]) begin
                    cfg_d.top[b] = wr_data[b + GRAN_LSB];
                end
            end
            if (wr_strb[0]) begin
                cfg_d.lock = wr_data[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.top  <= TOP_W'(TOP_RST);
            cfg_q.lock <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[DATA_W-1:GRAN_LSB]  = cfg_q.top;
        rd_data[0]                  = cfg_q.lock;
    end

    assign top_o  = cfg_q.top;
    assign lock_o = cfg_q.lock;

endmodule

// File: rtl/lmd_base_calc.sv
module lmd_base_calc #(
    parameter int TOP_W = 12
) (
    input  logic [TOP_W-1:0] top_i,
    input  logic             gfx_en_i,
    input  logic             gfx_sel_i,
    input  logic             seg_en_i,
    input  logic [1:0]       seg_sel_i,
    output logic [TOP_W-1:0] gfx_base_o,
    output logic [TOP_W-1:0] seg_base_o,
    output logic             underflow_o
);
    import lmd_pkg::*;

    logic [TOP_W-1:0] gfx_sz, seg_sz;
    logic [TOP_W:0]   gfx_diff, seg_diff;

    always_comb begin
        gfx_sz = gfx_en_i ? TOP_W'(gfx_mb(gfx_sel_i)) : '0;
        seg_sz = seg_en_i ? TOP_W'(seg_mb(seg_sel_i)) : '0;

        gfx_diff   = {1'b0, top_i} - {1'b0, gfx_sz};
        gfx_base_o = gfx_diff[TOP_W] ? '0 : gfx_diff[TOP_W-1:0];

        seg_diff   = {1'b0, gfx_base_o} - {1'b0, seg_sz};
        seg_base_o = seg_diff[TOP_W] ? '0 : seg_diff[TOP_W-1:0];

        underflow_o = gfx_diff[TOP_W] | seg_diff[TOP_W];
    end

endmodule

// File: rtl/lmd_classify.sv
module lmd_classify #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 20
) (
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [ADDR_W-GRAN_LSB-1:0] top_i,
    input  logic [ADDR_W-GRAN_LSB-1:0] gfx_base_i,
    input  logic [ADDR_W-GRAN_LSB-1:0] seg_base_i,
    input  logic                       gfx_en_i,
    input  logic                       seg_en_i,
    output logic [1:0]                 region_o
);
    import lmd_pkg::*;

    localparam int TOP_W = ADDR_W - GRAN_LSB;

    logic [TOP_W-1:0] hi;
    logic             unused_low;
    region_e          cls;

    assign hi         = addr_i[ADDR_W-1:GRAN_LSB];
    assign unused_low = ^addr_i[GRAN_LSB-1:0];

    always_comb begin
        if (hi >= top_i) begin
            cls = RG_NONDRAM;
        end else if (seg_en_i && hi >= seg_base_i && hi < gfx_base_i) begin
            cls = RG_SEG;
        end else if (gfx_en_i && hi >= gfx_base_i) begin
            cls = RG_GFX;
        end else begin
            cls = RG_DRAM;
        end
        region_o = cls;
    end

endmodule

// File: rtl/lowmem_region_decoder.sv
module lowmem_region_decoder #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 20,
    parameter int TOP_RST  = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr_en,
    input  logic [ADDR_W-1:0]          cfg_wr_data,
    input  logic [ADDR_W/8-1:0]        cfg_wr_strb,
    output logic [ADDR_W-1:0]          cfg_rd_data,
    input  logic                       plat_lock_i,
    input  logic                       gfx_en_i,
    input  logic                       gfx_sel_i,
    input  logic                       seg_en_i,
    input  logic [1:0]                 seg_sel_i,
    input  logic [ADDR_W-1:0]          addr_i,
    output logic [1:0]                 region_o,
    output logic [1:0]                 region_q,
    output logic [ADDR_W-GRAN_LSB-1:0] gfx_base_o,
    output logic [ADDR_W-GRAN_LSB-1:0] seg_base_o,
    output logic                       cfg_err_o
);
    localparam int TOP_W = ADDR_W - GRAN_LSB;

    typedef struct packed {
        logic [1:0] region;
        logic       err;
    } out_t;

    logic [TOP_W-1:0] top;
    logic             lock_bit;
    logic             underflow;
    logic [1:0]       region_c;
    logic             unused_lock;
    out_t             out_d, out_q;

    assign unused_lock = lock_bit;

    lmd_cfg_reg #(
        .DATA_W  (ADDR_W),
        .GRAN_LSB(GRAN_LSB),
        .TOP_RST (TOP_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .wr_strb  (cfg_wr_strb),
        .plat_lock(plat_lock_i),
        .top_o    (top),
        .lock_o   (lock_bit),
        .rd_data  (cfg_rd_data)
    );

    lmd_base_calc #(.TOP_W(TOP_W)) u_base (
        .top_i      (top),
        .gfx_en_i   (gfx_en_i),
        .gfx_sel_i  (gfx_sel_i),
        .seg_en_i   (seg_en_i),
        .seg_sel_i  (seg_sel_i),
        .gfx_base_o (gfx_base_o),
        .seg_base_o (seg_base_o),
        .underflow_o(underflow)
    );

    lmd_classify #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_cls (
        .addr_i    (addr_i),
        .top_i     (top),
        .gfx_base_i(gfx_base_o),
        .seg_base_i(seg_base_o),
        .gfx_en_i  (gfx_en_i),
        .seg_en_i  (seg_en_i),
        .region_o  (region_c)
    );

    always_comb begin
        out_d        = out_q;
        out_d.region = region_c;
        out_d.err    = out_q.err | underflow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign region_o  = region_c;
    assign region_q  = out_q.region;
    assign cfg_err_o = out_q.err;

endmodule

// File: rtl/lmd_checker.sv
module lmd_checker #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 20
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       plat_lock_i,
    input logic [ADDR_W-GRAN_LSB-1:0] top_i,
    input logic                       lock_i,
    input logic [ADDR_W-GRAN_LSB-1:0] addr_hi_i,
    input logic [1:0]                 region_o,
    input logic [1:0]                 region_q,
    input logic [ADDR_W-GRAN_LSB-1:0] gfx_base_o,
    input logic [ADDR_W-GRAN_LSB-1:0] seg_base_o,
    input logic                       cfg_err_o
);
    // R4: self-lock freezes the whole register
    a_r4_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> ($stable(top_i) && $stable(lock_i)));

    // R5: platform lock blocks the next update
    a_r5_plat_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        plat_lock_i |=> ($stable(top_i) && $stable(lock_i)));

    // R6: stacked bases never exceed what lies above them
    a_r6_base_order: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_base_o <= gfx_base_o) && (gfx_base_o <= top_i));

    // R7: the error flag never clears outside reset
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);

    // R8: at or above the limit is never DRAM-side
    a_r8_above_top: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hi_i >= top_i) |-> (region_o == 2'd0));

    // R8: a secure hit lies inside its window
    a_r8_seg_window: assert property (@(posedge clk) disable iff (!rst_n)
        (region_o == 2'd3) |-> (addr_hi_i >= seg_base_o && addr_hi_i < gfx_base_o));

    // R9: registered class trails the live class by one cycle
    a_r9_reg_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (region_q == $past(region_o)));

endmodule

bind lowmem_region_decoder lmd_checker #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .plat_lock_i(plat_lock_i),
    .top_i      (cfg_rd_data[ADDR_W-1:GRAN_LSB]),
    .lock_i     (cfg_rd_data[0]),
    .addr_hi_i  (addr_i[ADDR_W-1:GRAN_LSB]),
    .region_o   (region_o),
    .region_q   (region_q),
    .gfx_base_o (gfx_base_o),
    .seg_base_o (seg_base_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/lowmem_region_decoder_bench.sv
module lowmem_region_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [3:0]  cfg_wr_strb = '0;
    logic [31:0] cfg_rd_data;
    logic        plat_lock_i = 1'b0;
    logic        gfx_en_i = 1'b0;
    logic        gfx_sel_i = 1'b0;
    logic        seg_en_i = 1'b0;
    logic [1:0]  seg_sel_i = '0;
    logic [31:0] addr_i = '0;
    logic [1:0]  region_o, region_q;
    logic [11:0] gfx_base_o, seg_base_o;
    logic        cfg_err_o;

    int vectors = 0;
    int fails = 0;

    // reference state
    int unsigned top_m = 1;
    logic        lock_m = 1'b0;
    logic        err_m = 1'b0;
    int unsigned prev_cls = 1;

    always #5 clk = ~clk;

    lowmem_region_decoder u_lowmem_region_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_wr_strb(cfg_wr_strb), .cfg_rd_data(cfg_rd_data), .plat_lock_i(plat_lock_i),
        .gfx_en_i(gfx_en_i), .gfx_sel_i(gfx_sel_i), .seg_en_i(seg_en_i), .seg_sel_i(seg_sel_i),
        .addr_i(addr_i), .region_o(region_o), .region_q(region_q),
        .gfx_base_o(gfx_base_o), .seg_base_o(seg_base_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int unsigned g_size(input logic en, input logic sel);
        if (!en) return 0;
        return sel ? 2 : 1;
    endfunction

    function automatic int unsigned s_size(input logic en, input logic [1:0] sel);
        if (!en) return 0;
        if (sel == 2'b00) return 1;
        if (sel == 2'b01) return 2;
        return 8;
    endfunction

    // one cycle: drive at negedge, check live outputs, advance the model
    task automatic step(input logic we, input logic [31:0] wd, input logic [3:0] ws,
                        input logic pl, input logic ge, input logic gs,
                        input logic se, input logic [1:0] ss, input logic [31:0] a);
        int unsigned gb, sb, hi, cls;
        logic uf;
        @(negedge clk);
        cfg_wr_en = we; cfg_wr_data = wd; cfg_wr_strb = ws; plat_lock_i = pl;
        gfx_en_i = ge; gfx_sel_i = gs; seg_en_i = se; seg_sel_i = ss; addr_i = a;
        #1;
        uf = 1'b0;
        if (g_size(ge, gs) > top_m) begin gb = 0; uf = 1'b1; end
        else gb = top_m - g_size(ge, gs);
        if (s_size(se, ss) > gb) begin sb = 0; uf = 1'b1; end
        else sb = gb - s_size(se, ss);
        hi = a >> 20;
        if (hi >= top_m) cls = 0;
        else if (se && hi >= sb && hi < gb) cls = 3;
        else if (ge && hi >= gb) cls = 2;
        else cls = 1;
        check("R2 R3 R4 R5 read value", cfg_rd_data, {top_m[11:0], 19'd0, lock_m});
        check("R6 R7 graphics base", {20'd0, gfx_base_o}, gb);
        check("R6 R7 secure base", {20'd0, seg_base_o}, sb);
        check("R8 live class", {30'd0, region_o}, cls);
        check("R9 registered class", {30'd0, region_q}, prev_cls);
        check("R7 sticky error", {31'd0, cfg_err_o}, {31'd0, err_m});
        err_m = err_m | uf;
        if (we && !lock_m && !pl) begin
            if (ws[3]) top_m = (top_m & 32'h00F) | ({24'd0, wd[31:24]} << 4);
            if (ws[2]) top_m = (top_m & 32'hFF0) | {28'd0, wd[23:20]};
            if (ws[0]) lock_m = wd[0];
        end
        prev_cls = cls;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R1: values during reset
        check("R1 reset read", cfg_rd_data, 32'h0010_0000);
        check("R1 reset error", {31'd0, cfg_err_o}, 32'd0);
        check("R1 reset class", {30'd0, region_q}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 after reset, idle
        step(0, 0, 4'h0, 0, 0, 0, 0, 2'b00, 32'h0000_0000);
        // R2: reserved bits written as ones stay zero
        step(1, 32'hFFFF_FFFE, 4'hF, 0, 0, 0, 0, 2'b00, 32'h1234_5678);
        // R3: strobe 2 only touches limit nibble
        step(1, 32'h0050_0000, 4'h4, 0, 0, 0, 0, 2'b00, 32'hFFF0_0000);
        // R3: strobe 1 has no effect
        step(1, 32'h0000_FF00, 4'h2, 0, 0, 0, 0, 2'b00, 32'hFF4F_FFFF);
        // R3: strobe 3 only touches upper byte
        step(1, 32'h0C00_0000, 4'h8, 0, 0, 0, 0, 2'b00, 32'hFF50_0000);
        step(1, 32'hC000_0000, 4'hC, 0, 0, 0, 0, 2'b00, 32'h0C40_0000);
        // R6 R8: limit 0xC00, graphics 2 MB, secure 1 MB
        step(0, 0, 4'h0, 0, 1, 1, 1, 2'b00, 32'hBFD0_0000);
        step(0, 0, 4'h0, 0, 1, 1, 1, 2'b00, 32'hBFCF_FFFF);
        step(0, 0, 4'h0, 0, 1, 1, 1, 2'b00, 32'hBFE0_0000);
        step(0, 0, 4'h0, 0, 1, 1, 1, 2'b00, 32'hBFFF_FFFF);
        step(0, 0, 4'h0, 0, 1, 1, 1, 2'b00, 32'hC000_0000);
        // R6: disabled graphics area passes the limit down; secure 8 MB
        step(0, 0, 4'h0, 0, 0, 1, 1, 2'b11, 32'hBF80_0000);
        step(0, 0, 4'h0, 0, 1, 0, 0, 2'b10, 32'hBFF0_0000);
        // R5: platform lock blocks a write
        step(1, 32'h4000_0000, 4'hF, 1, 1, 0, 1, 2'b01, 32'h3FF0_0000);
        step(0, 0, 4'h0, 0, 1, 0, 1, 2'b01, 32'hBFC0_0000);
        // R7: underflow clamps and sets the flag
        step(1, 32'h0020_0000, 4'hF, 0, 0, 0, 0, 2'b00, 32'h0010_0000);
        step(0, 0, 4'h0, 0, 1, 1, 1, 2'b10, 32'h0010_0000);
        step(0, 0, 4'h0, 0, 0, 0, 0, 2'b00, 32'h0010_0000);
        step(0, 0, 4'h0, 0, 0, 0, 0, 2'b00, 32'h0000_0000);
        // random phase, lock bit held clear
        for (int i = 0; i < 400; i++) begin
            logic [31:0] wd, a;
            logic [11:0] b;
            int unsigned pick;
            wd = $urandom() & 32'hFFFF_FFFE;
            pick = $urandom_range(0, 2);
            b = (pick == 0) ? top_m[11:0] : (pick == 1) ? gfx_base_o : seg_base_o;
            if ($urandom_range(0, 1) == 1) a = $urandom();
            else a = {b, 20'h0} + 32'($urandom_range(0, 2)) - 32'd1;
            step($urandom_range(0, 3) == 0, wd, 4'($urandom()),
                 $urandom_range(0, 4) == 0, 1'($urandom()), 1'($urandom()),
                 1'($urandom()), 2'($urandom()), a);
        end
        // R4: set the lock, then try to change the limit and clear the lock
        step(1, 32'h8000_0001, 4'hF, 0, 1, 0, 1, 2'b01, 32'h7FE0_0000);
        step(1, 32'h2000_0000, 4'hF, 0, 1, 0, 1, 2'b01, 32'h7FD0_0000);
        step(1, 32'h0000_0000, 4'h1, 0, 1, 1, 0, 2'b00, 32'h7FF0_0000);
        step(0, 0, 4'h0, 0, 1, 1, 1, 2'b01, 32'h8000_0000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule